// File: doc/BRIEF.md
# BCD Calendar Core with Two-Stage Prescaler

This block keeps wall-clock time and calendar date in packed BCD words. It runs from a slow kernel clock. A cascade of two down-counters turns that clock into a one-second tick. The first stage is a short "asynchronous" divider and the second is a longer "synchronous" divider that steps once per first-stage wrap. Each tick advances seconds, minutes and hours in 24-hour form. A day carry then advances the date, the month and a two-digit year. It also steps a weekday field that is encoded on its own, apart from the date.

Software-side logic sets up the core by holding it in an initialization state and strobing a parallel load. The load captures both divider reload values, the time word and the date word in one cycle. Counting is frozen while the hold is asserted. When the hold is released, both dividers start again from their reload values, so the first tick arrives exactly one full period later. The current time and date words are always visible on the outputs, and a one-cycle pulse marks each update.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the time word reads 0x000000 and the date word reads 0x002101 (day 01, month 01, weekday 1, year 00). The tick pulse is low, and the reload values are the parameter defaults, 127 for the first stage and 255 for the second.
- R2: With first-stage reload A and second-stage reload S, a tick occurs every (A+1)×(S+1) clock cycles. The first tick comes on the (A+1)×(S+1)-th rising edge after reset or hold release, and the words change on that same edge. The tick pulse is high in the cycle that follows.
- R3: While the hold input is high, the time and date words do not change unless a load is applied, and no tick pulse is produced.
- R4: A load strobe only takes effect while the hold is high. A strobe with the hold low changes neither the time and date words nor the tick period. The prescaler word layout is: first-stage reload in bits 22:16 and second-stage reload in bits 14:0.
- R5: The time word layout is: BCD seconds in bits 6:0, BCD minutes in bits 14:8 and BCD hours in bits 21:16. A units digit of 9 rolls over to 0 and carries into the tens digit. Seconds 59 become 00 and carry into minutes; minutes 59 become 00 and carry into hours.
- R6: Hours run from 00 to 23. A tick at 23:59:59 gives 00:00:00 and carries into the date. At every other time of day, the date word stays the same across a tick.
- R7: The weekday field sits in bits 15:13 of the date word and is encoded 1 = Monday through 7 = Sunday. It advances by one at midnight, and 7 wraps to 1.
- R8: The date word layout is: BCD day in bits 5:0 and BCD month in bits 12:8. Months 04, 06, 09 and 11 end after day 30, and every other month except February ends after day 31. After the last day, the day becomes 01 and the month advances.
- R9: February ends after day 29 when the BCD year (bits 23:16) is divisible by 4, and after day 28 otherwise.
- R10: Month 12 followed by a day carry gives month 01 and advances the BCD year. Year 99 wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | Initialization hold: freezes counting and enables loading |
| load_i | input | 1 | Parallel load strobe, taken only while hold_i is high |
| prescale_i | input | 23 | Reload values: first stage in 22:16, second stage in 14:0 |
| time_i | input | 32 | Packed BCD time to load |
| date_i | input | 32 | Packed BCD date to load |
| time_o | output | 32 | Current packed BCD time |
| date_o | output | 32 | Current packed BCD date |
| tick_o | output | 1 | One-cycle pulse after each one-second update |

## Verification
The bench measures the edge on which the tick lands for three divider settings, including the defaults after reset. A divider that restarted one count early or late would shift the tick by a whole cycle and be caught. It loads moments just before the end of each kind of month, before the end of February in both leap and common years, and before the end of years 25 and 99. A wrong days-per-month table, a wrong leap rule or a missing year wrap would show up as a wrong date after midnight. It checks a carry from a units digit of 9 into the tens digit, a carry from hour 09 to 10 and the weekday wrap from 7 to 1. It also strobes a load with garbage values while the core is counting. A core that accepted that load would show the garbage value or a changed tick period.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    // Packed time word: BCD fields with zero gaps between them
    typedef struct packed {
        logic [9:0] pad_hi;
        logic [5:0] hour;
        logic       pad_m;
        logic [6:0] minute;
        logic       pad_s;
        logic [6:0] second;
    } time_word_t;

    // Packed date word: weekday shares the byte above the month
    typedef struct packed {
        logic [7:0] pad_hi;
        logic [7:0] year;
        logic [2:0] wday;
        logic [4:0] month;
        logic [1:0] pad_d;
        logic [5:0] day;
    } date_word_t;

    localparam time_word_t TIME_AT_RESET = 32'h0000_0000;
    localparam date_word_t DATE_AT_RESET = 32'h0000_2101;
    localparam time_word_t LAST_SECOND   = 32'h0023_5959;

    // Increment a two-digit BCD value (caller handles the upper wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is a multiple of four when the tens digit is even and the
    // units digit is 0, 4 or 8, or the tens digit is odd and units is 2 or 6
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic leap);
        logic [5:0] r;
        case (m)
            5'h02:                      r = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

    function automatic time_word_t clean_time(input time_word_t t);
        time_word_t r;
        r        = t;
        r.pad_hi = '0;
        r.pad_m  = 1'b0;
        r.pad_s  = 1'b0;
        return r;
    endfunction

    function automatic date_word_t clean_date(input date_word_t d);
        date_word_t r;
        r        = d;
        r.pad_hi = '0;
        r.pad_d  = '0;
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int ASYNC_W   = 7,
    parameter int SYNC_W    = 15,
    parameter int ASYNC_DEF = 127,
    parameter int SYNC_DEF  = 255
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold_i,
    input  logic               load_i,
    input  logic [ASYNC_W-1:0] async_rl_i,
    input  logic [SYNC_W-1:0]  sync_rl_i,
    output logic               sec_pulse_o
);
    logic [ASYNC_W-1:0] a_rl_q, a_cnt_q;
    logic [SYNC_W-1:0]  s_rl_q, s_cnt_q;
    logic               a_end, s_end;

    assign a_end       = (a_cnt_q == '0);
    assign s_end       = (s_cnt_q == '0);
    assign sec_pulse_o = !hold_i && a_end && s_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_rl_q  <= ASYNC_W'(ASYNC_DEF);
            s_rl_q  <= SYNC_W'(SYNC_DEF);
            a_cnt_q <= ASYNC_W'(ASYNC_DEF);
            s_cnt_q <= SYNC_W'(SYNC_DEF);
        end else begin
            if (hold_i && load_i) begin
                a_rl_q <= async_rl_i;
                s_rl_q <= sync_rl_i;
            end
            if (hold_i) begin
                a_cnt_q <= a_rl_q;
                s_cnt_q <= s_rl_q;
            end else if (a_end) begin
                a_cnt_q <= a_rl_q;
                s_cnt_q <= s_end ? s_rl_q : s_cnt_q - 1'b1;
            end else begin
                a_cnt_q <= a_cnt_q - 1'b1;
            end
        end
    end

    AST_RELOAD_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hold_i && !load_i) |=> (a_cnt_q == a_rl_q) && (s_cnt_q == s_rl_q)); // R2

    AST_SYNC_STEPS_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !a_end) |=> $stable(s_cnt_q)); // R2

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_i,
    input  logic       load_i,
    input  logic       tick_i,
    input  time_word_t time_i,
    input  date_word_t date_i,
    output time_word_t time_o,
    output date_word_t date_o
);
    time_word_t time_q, time_n;
    date_word_t date_q, date_n;
    logic       sec_wrap, min_wrap, hour_wrap, day_roll;
    logic       day_wrap, mon_wrap;
    logic [5:0] last_day;

    always_comb begin
        sec_wrap  = (time_q.second == 7'h59);
        min_wrap  = (time_q.minute == 7'h59);
        hour_wrap = (time_q.hour == 6'h23);
        day_roll  = sec_wrap && min_wrap && hour_wrap;
        last_day  = month_last_day(date_q.month, leap_year(date_q.year));
        day_wrap  = (date_q.day == last_day);
        mon_wrap  = (date_q.month == 5'h12);

        time_n = time_q;
        date_n = date_q;

        time_n.second = sec_wrap ? 7'h00 : 7'(bcd_inc({1'b0, time_q.second}));
        if (sec_wrap)
            time_n.minute = min_wrap ? 7'h00 : 7'(bcd_inc({1'b0, time_q.minute}));
        if (sec_wrap && min_wrap)
            time_n.hour = hour_wrap ? 6'h00 : 6'(bcd_inc({2'b00, time_q.hour}));

        if (day_roll) begin
            date_n.wday = (date_q.wday == 3'd7) ? 3'd1 : date_q.wday + 3'd1;
            date_n.day  = day_wrap ? 6'h01 : 6'(bcd_inc({2'b00, date_q.day}));
            if (day_wrap) begin
                date_n.month = mon_wrap ? 5'h01 : 5'(bcd_inc({3'b000, date_q.month}));
                if (mon_wrap)
                    date_n.year = (date_q.year == 8'h99) ? 8'h00 : bcd_inc(date_q.year);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= TIME_AT_RESET;
            date_q <= DATE_AT_RESET;
        end else if (hold_i && load_i) begin
            time_q <= clean_time(time_i);
            date_q <= clean_date(date_i);
        end else if (tick_i) begin
            time_q <= time_n;
            date_q <= date_n;
        end
    end

    assign time_o = time_q;
    assign date_o = date_q;

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && time_q.second == 7'h59) |=> (time_q.second == 7'h00)); // R5

    AST_MIDNIGHT: assert property (@(posedge clk) disable iff (rst)
        (tick_i && time_q == LAST_SECOND) |=> (time_q == TIME_AT_RESET)); // R6

    AST_DATE_HELD_INTRADAY: assert property (@(posedge clk) disable iff (rst)
        (tick_i && time_q != LAST_SECOND) |=> $stable(date_q)); // R6

    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && time_q == LAST_SECOND && date_q.wday == 3'd7) |=> (date_q.wday == 3'd1)); // R7

    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && time_q == LAST_SECOND && date_q.month == 5'h12 &&
         date_q.day == 6'h31 && date_q.year == 8'h99) |=> (date_q.year == 8'h00)); // R10

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_cal_pkg::*;
#(
    parameter int ASYNC_W   = 7,
    parameter int SYNC_W    = 15,
    parameter int ASYNC_DEF = 127,
    parameter int SYNC_DEF  = 255,
    localparam int ASYNC_LSB = 16,
    localparam int PRE_W     = ASYNC_LSB + ASYNC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_i,
    input  logic             load_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic [31:0]      time_i,
    input  logic [31:0]      date_i,
    output logic [31:0]      time_o,
    output logic [31:0]      date_o,
    output logic             tick_o
);
    logic       sec_pulse;
    time_word_t cal_time;
    date_word_t cal_date;

    rtc_prescaler #(
        .ASYNC_W  (ASYNC_W),
        .SYNC_W   (SYNC_W),
        .ASYNC_DEF(ASYNC_DEF),
        .SYNC_DEF (SYNC_DEF)
    ) u_pre (
        .clk        (clk),
        .rst        (rst),
        .hold_i     (hold_i),
        .load_i     (load_i),
        .async_rl_i (prescale_i[ASYNC_LSB +: ASYNC_W]),
        .sync_rl_i  (prescale_i[SYNC_W-1:0]),
        .sec_pulse_o(sec_pulse)
    );

    rtc_calendar u_cal (
        .clk   (clk),
        .rst   (rst),
        .hold_i(hold_i),
        .load_i(load_i),
        .tick_i(sec_pulse),
        .time_i(time_word_t'(time_i)),
        .date_i(date_word_t'(date_i)),
        .time_o(cal_time),
        .date_o(cal_date)
    );

    always_ff @(posedge clk) begin
        if (rst) tick_o <= 1'b0;
        else     tick_o <= sec_pulse;
    end

    assign time_o = cal_time;
    assign date_o = cal_date;

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (hold_i && !load_i) |=> $stable(time_o) && $stable(date_o) && !tick_o); // R3

    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && load_i && !sec_pulse) |=> $stable(time_o) && $stable(date_o)); // R4

endmodule

// File: tb/sim_rtc_bcd_core.sv
`timescale 1ns/1ps
module sim_rtc_bcd_core;
    logic        clk = 1'b0;
    logic        rst, hold_i, load_i, tick_o;
    logic [22:0] prescale_i;
    logic [31:0] time_i, date_i, time_o, date_o;

    always #10 clk = ~clk;

    rtc_bcd_core u0 (
        .clk(clk), .rst(rst), .hold_i(hold_i), .load_i(load_i),
        .prescale_i(prescale_i), .time_i(time_i), .date_i(date_i),
        .time_o(time_o), .date_o(date_o), .tick_o(tick_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_t[$];
    logic [31:0] exp_d[$];
    string       exp_tag[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] t, input logic [31:0] d, input string tag);
        exp_t.push_back(t);
        exp_d.push_back(d);
        exp_tag.push_back(tag);
    endtask

    // Monitor: each tick pulse pops one expected calendar state
    always @(negedge clk) begin
        if (!rst && tick_o) begin
            if (exp_t.size() == 0) begin
                check(1'b0, "R2 unexpected tick", time_o, 32'h0);
            end else begin
                logic [31:0] et, ed;
                string tg;
                et = exp_t.pop_front();
                ed = exp_d.pop_front();
                tg = exp_tag.pop_front();
                check(time_o == et, {tg, " time"}, time_o, et);
                check(date_o == ed, {tg, " date"}, date_o, ed);
            end
        end
    end

    task automatic load_held(input int a, input int s, input logic [31:0] t, input logic [31:0] d);
        @(negedge clk);
        hold_i     = 1'b1;
        load_i     = 1'b1;
        prescale_i = {7'(a), 1'b0, 15'(s)};
        time_i     = t;
        date_i     = d;
        @(negedge clk);
        load_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic release_hold();
        hold_i = 1'b0;
    endtask

    // Expect k ticks, each exactly n edges after the previous one
    task automatic wait_ticks(input int n, input int k, input string tag);
        for (int i = 0; i < k; i++) begin
            repeat (n - 1) @(negedge clk);
            check(tick_o == 1'b0, {tag, " early tick"}, {31'b0, tick_o}, 32'h0);
            @(negedge clk);
            check(tick_o == 1'b1, {tag, " tick missing"}, {31'b0, tick_o}, 32'h1);
        end
    endtask

    task automatic rollover(input logic [31:0] t0, input logic [31:0] d0,
                            input logic [31:0] t1, input logic [31:0] d1, input string tag);
        load_held(1, 1, t0, d0);
        push(t1, d1, tag);
        release_hold();
        wait_ticks(4, 1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; hold_i = 1'b0; load_i = 1'b0;
        prescale_i = '0; time_i = '0; date_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        check(time_o == 32'h0, "R1 reset time", time_o, 32'h0);
        check(date_o == 32'h0000_2101, "R1 reset date", date_o, 32'h0000_2101);
        check(tick_o == 1'b0, "R1 reset tick", {31'b0, tick_o}, 32'h0);
        // R1/R2: default dividers give a 128*256 cycle period
        push(32'h0000_0001, 32'h0000_2101, "R1 default period");
        wait_ticks(128 * 256, 1, "R1 R2 default period");

        // R3: hold freezes loaded state, no tick
        load_held(1, 1, 32'h0012_3456, 32'h0025_2430);
        repeat (40) begin
            @(negedge clk);
            if (tick_o) check(1'b0, "R3 tick during hold", 32'h1, 32'h0);
        end
        check(time_o == 32'h0012_3456, "R3 time frozen", time_o, 32'h0012_3456);
        check(date_o == 32'h0025_2430, "R3 date frozen", date_o, 32'h0025_2430);

        // R2 R5: A=2, S=3 -> 12-cycle period, units-digit carry
        load_held(2, 3, 32'h0000_0009, 32'h0000_2101);
        push(32'h0000_0010, 32'h0000_2101, "R5 units carry");
        push(32'h0000_0011, 32'h0000_2101, "R2 second tick");
        release_hold();
        wait_ticks(12, 2, "R2 period 12");

        // R4: load while running is ignored
        load_held(1, 1, 32'h0012_3459, 32'h0000_2101);
        push(32'h0012_3500, 32'h0000_2101, "R4 R5 minute carry");
        push(32'h0012_3501, 32'h0000_2101, "R4 period kept");
        release_hold();
        @(negedge clk);
        load_i = 1'b1; time_i = 32'h0099_9999; date_i = 32'h0099_1299; prescale_i = '0;
        @(negedge clk);
        load_i = 1'b0;
        check(time_o == 32'h0012_3459, "R4 load ignored time", time_o, 32'h0012_3459);
        @(negedge clk);
        check(tick_o == 1'b0, "R4 early tick", {31'b0, tick_o}, 32'h0);
        @(negedge clk);
        check(tick_o == 1'b1, "R4 tick missing", {31'b0, tick_o}, 32'h1);
        wait_ticks(4, 1, "R4 second period");

        // R5 R6: hour digit carry
        rollover(32'h0009_5959, 32'h0025_2430, 32'h0010_0000, 32'h0025_2430, "R5 hour 09->10");

        // R6 R7 R10: last second of year 99, Sunday
        load_held(1, 1, 32'h0023_5958, 32'h0099_F231);
        push(32'h0023_5959, 32'h0099_F231, "R6 date held intraday");
        push(32'h0000_0000, 32'h0000_2101, "R10 R7 year 99 wrap");
        release_hold();
        wait_ticks(4, 2, "R6 year end");

        // R9: February, leap and common years
        rollover(32'h0023_5959, 32'h0024_6228, 32'h0, 32'h0024_8229, "R9 Feb 28 leap");
        rollover(32'h0023_5959, 32'h0023_4228, 32'h0, 32'h0023_6301, "R9 Feb 28 common");
        rollover(32'h0023_5959, 32'h0024_8229, 32'h0, 32'h0024_A301, "R9 Feb 29 leap");

        // R8: 30- and 31-day months
        rollover(32'h0023_5959, 32'h0025_2430, 32'h0, 32'h0025_4501, "R8 Apr 30");
        rollover(32'h0023_5959, 32'h0025_A131, 32'h0, 32'h0025_C201, "R8 Jan 31");
        rollover(32'h0023_5959, 32'h0025_C930, 32'h0, 32'h0025_F001, "R8 R7 Sep 30");
        rollover(32'h0023_5959, 32'h0025_6831, 32'h0, 32'h0025_8901, "R8 Aug 31");

        // R10: year advance
        rollover(32'h0023_5959, 32'h0025_5231, 32'h0, 32'h0026_6101, "R10 Dec 31 25");

        @(negedge clk);
        hold_i = 1'b1;
        @(negedge clk);
        check(exp_t.size() == 0, "R2 pending expectations", exp_t.size(), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule